// File: doc/BRIEF.md
# Next Program Counter Sequencer

This block holds the program counter of a single-cycle 32-bit processor and works out, in the same cycle, where the next instruction comes from. The current PC is incremented by one word for sequential flow. A PC-relative branch target is formed from the 16-bit offset field of the instruction word, and a region-local jump target from its 26-bit index field. One of the three candidates is chosen from the branch and jump control bits and the equality flag of the ALU, and the PC register loads the chosen value on every rising clock edge.

The instruction word comes from the instruction memory and the control bits come from the main decoder, all in the same cycle. The three candidate addresses and the chosen one are also driven out so the rest of the datapath can use them. The selection is modelled as a small set of named sources: **SEQ** (fall through), **BRANCH** (taken PC-relative branch) and **JUMP** (absolute jump within the current 256 MB region). In every cycle one source is selected combinationally. The PC register is the only stored state. Synchronous reset is the only transition that does not go through the selector, and it forces the register to the reset vector.

Top module: `pc_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_q` holds `RESET_VEC` (default 0x00000000) after that edge, whatever the other inputs are.
- R2: `pc_plus4` always equals `pc_q + 4` modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.
- R3: `br_target` always equals `pc_plus4` plus the 16-bit field `instr[15:0]`, sign-extended to 32 bits and multiplied by 4.
- R4: `jmp_target` always equals bits 31..28 of `pc_plus4`, then `instr[25:0]`, then two zero bits.
- R5: When `jmp_en` is 0, `br_en` is 1 and `alu_zero` is 1, `pc_next` equals `br_target` (source BRANCH).
- R6: When `jmp_en` is 0 and `br_en` and `alu_zero` are not both 1, `pc_next` equals `pc_plus4` (source SEQ). `alu_zero` alone and `br_en` alone have no effect.
- R7: When `jmp_en` is 1, `pc_next` equals `jmp_target`, whatever `br_en` and `alu_zero` are (source JUMP has priority).
- R8: Outside reset, `pc_q` loads `pc_next` at every rising edge. There is no write enable.
- R9: A negative branch offset moves the PC backwards with wraparound. From PC 0x00010000, offset 0xFFFE gives 0x0000FFFC. From PC 0x00000000, the same offset gives 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word fetched at `pc_q` |
| alu_zero | input | 1 | ALU equality flag (1 when the two operands are equal) |
| br_en | input | 1 | Conditional branch control bit |
| jmp_en | input | 1 | Unconditional jump control bit |
| pc_q | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential successor of `pc_q` |
| br_target | output | 32 | PC-relative branch target |
| jmp_target | output | 32 | Region-local jump target |
| pc_next | output | 32 | Selected next program counter |

## Verification
The assertions assume that `rst`, `br_en`, `jmp_en`, `alu_zero` and `instr` carry known values at every clock edge. They also assume these inputs settle between edges, because the selector and both target adders are purely combinational from them. The reset check further assumes that the reset vector is a legal PC. The stimulus keeps to these assumptions: every input is updated shortly after a falling edge with fully defined values, and reset is pulsed several times, including in cycles where a jump and a taken branch are both requested.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Source chosen for the next program counter
    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2
    } npc_src_e;

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] pc_cur,
    output logic [ADDR_W-1:0] pc_inc
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Modulo 2^ADDR_W increment by one instruction word
    assign pc_inc = pc_cur + STEP_V;
endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int SH     = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFF_W - SH;

    logic [ADDR_W-1:0] disp;

    // Sign-extend the word offset and scale it to a byte displacement
    assign disp   = {{EXT_W{offset[OFF_W-1]}}, offset, {SH{1'b0}}};
    assign target = base + disp;
endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 26,
    parameter int SH     = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] target
);
    localparam int HI_W = ADDR_W - IDX_W - SH;

    // Keep the region bits of the incremented PC, replace the rest
    assign target = {base[ADDR_W-1 -: HI_W], index, {SH{1'b0}}};
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              br_en,
    input  logic              alu_zero,
    input  logic              jmp_en,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    output logic [ADDR_W-1:0] next_addr
);
    npc_src_e src;

    // Source decision: jump outranks a taken branch
    always_comb begin
        if (jmp_en)
            src = NPC_JUMP;
        else if (br_en && alu_zero)
            src = NPC_BRANCH;
        else
            src = NPC_SEQ;
    end

    // Address steering per source
    always_comb begin
        unique case (src)
            NPC_JUMP:   next_addr = jmp_addr;
            NPC_BRANCH: next_addr = br_addr;
            default:    next_addr = seq_addr;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
    parameter int          ADDR_W    = 32,
    parameter int          INSTR_W   = 32,
    parameter int          OFF_W     = 16,
    parameter int          IDX_W     = 26,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               alu_zero,
    input  logic               br_en,
    input  logic               jmp_en,
    output logic [ADDR_W-1:0]  pc_q,
    output logic [ADDR_W-1:0]  pc_plus4,
    output logic [ADDR_W-1:0]  br_target,
    output logic [ADDR_W-1:0]  jmp_target,
    output logic [ADDR_W-1:0]  pc_next
);
    localparam int STEP = INSTR_W / 8;
    localparam int SH   = $clog2(STEP);

    logic op_unused;
    assign op_unused = ^instr[INSTR_W-1:IDX_W];

    npc_incr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_incr (
        .pc_cur (pc_q),
        .pc_inc (pc_plus4)
    );

    npc_branch_tgt #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SH(SH)) u_br (
        .base   (pc_plus4),
        .offset (instr[OFF_W-1:0]),
        .target (br_target)
    );

    npc_jump_tgt #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SH(SH)) u_jmp (
        .base   (pc_plus4),
        .index  (instr[IDX_W-1:0]),
        .target (jmp_target)
    );

    npc_select #(.ADDR_W(ADDR_W)) u_sel (
        .br_en     (br_en),
        .alu_zero  (alu_zero),
        .jmp_en    (jmp_en),
        .seq_addr  (pc_plus4),
        .br_addr   (br_target),
        .jmp_addr  (jmp_target),
        .next_addr (pc_next)
    );

    // Program counter register: loads every edge, reset is synchronous
    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_VEC[ADDR_W-1:0];
        else
            pc_q <= pc_next;
    end
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              alu_zero,
    input logic              br_en,
    input logic              jmp_en,
    input logic [ADDR_W-1:0] pc_q,
    input logic [ADDR_W-1:0] pc_plus4,
    input logic [ADDR_W-1:0] br_target,
    input logic [ADDR_W-1:0] jmp_target,
    input logic [ADDR_W-1:0] pc_next
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d === 1'b1)
            AST_RESET_LOAD: assert (pc_q == RESET_VEC[ADDR_W-1:0]); // R1
    end

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_q == $past(pc_next)); // R8

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!jmp_en && br_en && alu_zero) |-> pc_next == br_target); // R5

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (!jmp_en && !(br_en && alu_zero)) |-> pc_next == pc_plus4); // R6

    AST_JUMP_WINS: assert property (@(posedge clk) disable iff (rst)
        jmp_en |-> pc_next == jmp_target); // R7

    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
        jmp_en |-> (pc_next[ADDR_W-1 -: 4] == pc_plus4[ADDR_W-1 -: 4]
                    && pc_next[1:0] == 2'b00)); // R4
endmodule

bind pc_sequencer pc_sequencer_chk #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .alu_zero   (alu_zero),
    .br_en      (br_en),
    .jmp_en     (jmp_en),
    .pc_q       (pc_q),
    .pc_plus4   (pc_plus4),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .pc_next    (pc_next)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        alu_zero = 1'b0;
    logic        br_en = 1'b0;
    logic        jmp_en = 1'b0;
    logic [31:0] pc_q, pc_plus4, br_target, jmp_target, pc_next;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] ref_pc;

    always #4 clk = ~clk; // 125 MHz

    pc_sequencer dut (
        .clk(clk), .rst(rst), .instr(instr), .alu_zero(alu_zero),
        .br_en(br_en), .jmp_en(jmp_en), .pc_q(pc_q), .pc_plus4(pc_plus4),
        .br_target(br_target), .jmp_target(jmp_target), .pc_next(pc_next)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, check combinational outputs,
    // advance the model, then check the register after the next rising edge.
    task automatic step(input logic r, input logic [31:0] ins, input logic z,
                        input logic b, input logic j, input string tag);
        logic [31:0] e_p4, e_bt, e_jt, e_nx;
        int off;
        rst = r; instr = ins; alu_zero = z; br_en = b; jmp_en = j;
        #1;
        e_p4 = ref_pc + 32'd4;
        off  = int'($signed(ins[15:0]));
        e_bt = e_p4 + 32'(off * 4);
        e_jt = (e_p4 & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) << 2);
        if (j)           e_nx = e_jt;
        else if (b && z) e_nx = e_bt;
        else             e_nx = e_p4;
        chk("R2", pc_plus4, e_p4);
        chk("R3", br_target, e_bt);
        chk("R4", jmp_target, e_jt);
        if (!r) chk(tag, pc_next, e_nx);
        ref_pc = r ? 32'h0 : e_nx;
        @(negedge clk);
        chk(r ? "R1" : "R8", pc_q, ref_pc);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", pc_q, 32'h0);
        ref_pc = 32'h0;
        step(1'b0, 32'h0,        1'b0, 1'b0, 1'b0, "R6"); // 0 -> 4
        step(1'b0, 32'h0000_0010, 1'b0, 1'b1, 1'b0, "R6"); // branch, not equal -> 8
        step(1'b0, 32'h0000_0010, 1'b1, 1'b0, 1'b0, "R6"); // zero alone -> 12
        step(1'b0, 32'h0000_0003, 1'b1, 1'b1, 1'b0, "R5"); // 16 + 12 = 28
        step(1'b0, 32'h0000_4000, 1'b0, 1'b0, 1'b1, "R4"); // jump to 0x00010000
        chk("R4", pc_q, 32'h0001_0000);
        step(1'b0, 32'h0000_FFFE, 1'b1, 1'b1, 1'b0, "R9"); // back across boundary
        chk("R9", pc_q, 32'h0000_FFFC);
        step(1'b0, 32'h0000_0010, 1'b1, 1'b1, 1'b1, "R7"); // jump beats branch
        chk("R7", pc_q, 32'h0000_0040);
        step(1'b1, 32'h0000_0123, 1'b1, 1'b1, 1'b1, "R1"); // reset wins
        step(1'b0, 32'h0000_FFFE, 1'b1, 1'b1, 1'b0, "R9"); // 0 -> 0xFFFFFFFC
        chk("R9", pc_q, 32'hFFFF_FFFC);
        step(1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, "R2"); // wrap to 0
        chk("R2", pc_q, 32'h0);
        for (int i = 0; i < 300; i++) begin
            logic [3:0] k;
            k = 4'($urandom);
            step(k == 4'd0, $urandom, 1'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, "R8");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule